// File: doc/BRIEF.md
# Auto-Incrementing Configuration Register Loader

This block holds ten 8-bit configuration registers for a buffer controller and offers two ways to load them. In the parallel path the host drives the path-select line low and pulses the write strobe or the read strobe. No address travels with the strobe: a hidden index starts at the first register, steps one register per access and returns to the first after the tenth. Reads return the registers in the same order. When path-select is high, the strobes belong to the data buffer, and the block only forwards them.

The serial path is a shift input with its own clock and enable. A frame carries a register address and a data byte, so any register can be written directly. The serial clock, enable and data are sampled in the system clock domain and the serial clock's rising edges are detected there. Combinations of control inputs that make no sense are flagged and then suppressed. Reset restores every register to its default value. Bit 0 of register 3 is brought out as the two-queue mode select.

Top module: `cfgld_top`

## Requirements
- R1: With path_fifo low, each cycle with wr_en high (and rd_en low, ser_en low) stores wr_data[7:0] into the register at the hidden index, then advances the index by one. After reset the index points at register 1.
- R2: The index wraps: the access after the one to register 10 goes to register 1.
- R3: With path_fifo low, each cycle with rd_en high (and wr_en low, ser_en low) returns the register at the index on rd_data in the next cycle, with rd_valid high for that one cycle. The index then advances in the same order and with the same wrap as R1 and R2.
- R4: With path_fifo high, fifo_wr equals wr_en and fifo_rd equals rd_en in the same cycle. No register changes. The index returns to register 1.
- R5: A serial frame is 12 bits, sent MSB first: a 4-bit address, then 8 data bits. One bit is taken per rising edge of ser_clk while ser_en and path_fifo are high. The addressed register is written after the twelfth bit. Dropping ser_en discards a partial frame.
- R6: Frames with addresses 0 or 11 to 15 change no register.
- R7: ser_en high while path_fifo is low raises illegal in the same cycle. While it lasts, parallel strobes are ignored, the index holds, and no serial bit is taken.
- R8: wr_en and rd_en high together while path_fifo is low raise illegal. No access takes place, rd_valid stays low and the index holds.
- R9: Reset sets registers 1 to 9 to 0x00 and register 10 to 0x80. cfg_regs[8*k-1 -: 8] holds register k.
- R10: two_queue always equals bit 0 of register 3. After reset it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| path_fifo | input | 1 | 1: strobes go to the data buffer; 0: strobes access registers |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wr_data | input | DATA_W | Write data; bits 7:0 are used for registers |
| ser_clk | input | 1 | Serial shift clock, sampled |
| ser_en | input | 1 | Serial enable, active high |
| ser_din | input | 1 | Serial data, MSB first |
| fifo_wr | output | 1 | Write strobe forwarded to the data buffer |
| fifo_rd | output | 1 | Read strobe forwarded to the data buffer |
| rd_data | output | 8 | Register read data |
| rd_valid | output | 1 | rd_data valid pulse |
| illegal | output | 1 | Illegal control combination present |
| two_queue | output | 1 | Bit 0 of register 3 |
| cfg_regs | output | 8*NREG | All registers, flattened |

## Verification
A wrong index shows up as a rotated or shifted read sequence. If the index fails to wrap or to return to register 1, this is visible on the next parallel read, one cycle after the strobe. A corrupted serial shift count or address decode writes the wrong register, or none at all. This appears on cfg_regs a few cycles after the twelfth serial edge, and a full parallel read-back confirms it. A broken illegal-combination guard shows up either as an unchanged illegal output or as register contents that moved when they should not have.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;

  localparam int REG_W   = 8;
  localparam int FRAME_W = 12;
  localparam int SADDR_W = 4;

  // Reset value of the register at 0-based position pos.
  function automatic logic [REG_W-1:0] reset_value(int pos, int nreg);
    return (pos == nreg - 1) ? 8'h80 : 8'h00;
  endfunction

  // Next position of the parallel index, wrapping after the last one.
  function automatic int step_index(int cur, int nreg);
    return (cur + 1 >= nreg) ? 0 : cur + 1;
  endfunction

  // True when a serial address names an existing register (1..nreg).
  function automatic bit addr_hits(int addr, int nreg);
    return (addr >= 1) && (addr <= nreg);
  endfunction

endpackage

// File: rtl/cfgld_par_seq.sv
module cfgld_par_seq
  import cfgld_pkg::*;
#(
  parameter int NREG  = 10,
  parameter int IDX_W = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             path_fifo,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic             ser_en,
  output logic             par_we,
  output logic             par_re,
  output logic             fifo_wr,
  output logic             fifo_rd,
  output logic             illegal,
  output logic [IDX_W-1:0] idx
);

  logic bad_ser;
  logic bad_both;

  assign bad_ser  = !path_fifo && ser_en;
  assign bad_both = !path_fifo && wr_en && rd_en;
  assign illegal  = bad_ser || bad_both;

  assign par_we  = !path_fifo && wr_en && !illegal;
  assign par_re  = !path_fifo && rd_en && !illegal;
  assign fifo_wr = path_fifo && wr_en;
  assign fifo_rd = path_fifo && rd_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx <= '0;
    end else if (path_fifo) begin
      idx <= '0;
    end else if (par_we || par_re) begin
      idx <= IDX_W'(step_index(int'(idx), NREG));
    end
  end

endmodule

// File: rtl/cfgld_ser_rx.sv
module cfgld_ser_rx
  import cfgld_pkg::*;
#(
  parameter int NREG  = 10,
  parameter int IDX_W = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             path_fifo,
  input  logic             ser_clk,
  input  logic             ser_en,
  input  logic             ser_din,
  output logic             ser_we,
  output logic [IDX_W-1:0] ser_idx,
  output logic [REG_W-1:0] ser_data,
  output logic             frame_end
);

  localparam int CNT_W = $clog2(FRAME_W);

  // Sampled inputs, bit order {clock, enable, data}.
  logic [2:0] s1, s2, s3;
  logic [CNT_W-1:0] cnt;
  logic [FRAME_W-2:0] sh;
  logic [FRAME_W-1:0] frame_word;
  logic [SADDR_W-1:0] f_addr;
  logic bit_edge, active, take;

  assign bit_edge   = s2[2] && !s3[2];
  assign active     = s2[1] && path_fifo;
  assign take       = bit_edge && active;
  assign frame_word = {sh, s2[0]};
  assign f_addr     = frame_word[FRAME_W-1 -: SADDR_W];
  assign frame_end  = take && (cnt == CNT_W'(FRAME_W - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
      s3 <= '0;
    end else begin
      s1 <= {ser_clk, ser_en, ser_din};
      s2 <= s1;
      s3 <= s2;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      sh       <= '0;
      ser_we   <= 1'b0;
      ser_idx  <= '0;
      ser_data <= '0;
    end else begin
      ser_we <= 1'b0;
      if (!active) begin
        cnt <= '0;
      end else if (take) begin
        sh <= frame_word[FRAME_W-2:0];
        if (frame_end) begin
          cnt <= '0;
          if (addr_hits(int'(f_addr), NREG)) begin
            ser_we   <= 1'b1;
            ser_idx  <= IDX_W'(int'(f_addr) - 1);
            ser_data <= frame_word[REG_W-1:0];
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/cfgld_regfile.sv
module cfgld_regfile
  import cfgld_pkg::*;
#(
  parameter int NREG  = 10,
  parameter int IDX_W = $clog2(NREG)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we_a,
  input  logic [IDX_W-1:0]   idx_a,
  input  logic [REG_W-1:0]   data_a,
  input  logic               we_b,
  input  logic [IDX_W-1:0]   idx_b,
  input  logic [REG_W-1:0]   data_b,
  output logic [REG_W*NREG-1:0] regs_flat
);

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic [REG_W-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        q <= reset_value(i, NREG);
      end else if (we_a && (idx_a == IDX_W'(i))) begin
        q <= data_a;
      end else if (we_b && (idx_b == IDX_W'(i))) begin
        q <= data_b;
      end
    end
    assign regs_flat[i*REG_W +: REG_W] = q;
  end

endmodule

// File: rtl/cfgld_top.sv
module cfgld_top
  import cfgld_pkg::*;
#(
  parameter int DATA_W = 36,
  parameter int NREG   = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  path_fifo,
  input  logic                  wr_en,
  input  logic                  rd_en,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic                  ser_clk,
  input  logic                  ser_en,
  input  logic                  ser_din,
  output logic                  fifo_wr,
  output logic                  fifo_rd,
  output logic [7:0]            rd_data,
  output logic                  rd_valid,
  output logic                  illegal,
  output logic                  two_queue,
  output logic [8*NREG-1:0]     cfg_regs
);

  localparam int IDX_W = $clog2(NREG);

  logic             par_we, par_re;
  logic [IDX_W-1:0] par_idx;
  logic             ser_we;
  logic [IDX_W-1:0] ser_idx;
  logic [REG_W-1:0] ser_data;
  logic             frame_end;
  logic [REG_W-1:0] sel_reg;

  cfgld_par_seq #(.NREG(NREG), .IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .path_fifo(path_fifo),
    .wr_en(wr_en), .rd_en(rd_en), .ser_en(ser_en),
    .par_we(par_we), .par_re(par_re),
    .fifo_wr(fifo_wr), .fifo_rd(fifo_rd),
    .illegal(illegal), .idx(par_idx)
  );

  cfgld_ser_rx #(.NREG(NREG), .IDX_W(IDX_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .path_fifo(path_fifo),
    .ser_clk(ser_clk), .ser_en(ser_en), .ser_din(ser_din),
    .ser_we(ser_we), .ser_idx(ser_idx), .ser_data(ser_data),
    .frame_end(frame_end)
  );

  cfgld_regfile #(.NREG(NREG), .IDX_W(IDX_W)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .we_a(par_we), .idx_a(par_idx), .data_a(wr_data[REG_W-1:0]),
    .we_b(ser_we), .idx_b(ser_idx), .data_b(ser_data),
    .regs_flat(cfg_regs)
  );

  assign sel_reg   = cfg_regs[int'(par_idx)*REG_W +: REG_W];
  assign two_queue = cfg_regs[2*REG_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= par_re;
      if (par_re) rd_data <= sel_reg;
    end
  end

endmodule

// File: rtl/cfgld_chk.sv
module cfgld_chk #(
  parameter int NREG  = 10,
  parameter int IDX_W = $clog2(NREG)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             path_fifo,
  input logic             wr_en,
  input logic             rd_en,
  input logic             ser_en,
  input logic             illegal,
  input logic             rd_valid,
  input logic             par_we,
  input logic             par_re,
  input logic [IDX_W-1:0] par_idx,
  input logic             ser_we,
  input logic [IDX_W-1:0] ser_idx,
  input logic [8*NREG-1:0] cfg_regs
);

  // R2: access at the last register lands on the first next
  p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((par_we || par_re) && par_idx == IDX_W'(NREG - 1)) |=> (par_idx == '0));

  // R3: a parallel read produces one valid pulse next cycle
  p_rdvalid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    par_re |=> rd_valid);

  // R4: buffer path performs no register access and homes the index
  p_fifo_path_r4: assert property (@(posedge clk) disable iff (!rst_n)
    path_fifo |-> (!par_we && !par_re));
  p_home_r4: assert property (@(posedge clk) disable iff (!rst_n)
    path_fifo |=> (par_idx == '0));

  // R6: serial writes only target existing registers
  p_ser_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ser_we |-> (int'(ser_idx) < NREG));

  // R7, R8: flagged combinations suppress access and hold the index
  p_illegal_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!par_we && !par_re));
  p_illegal_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (illegal && !path_fifo) |=> $stable(par_idx));

  // R5: registers change only through a write port
  p_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ser_we && !par_we) |=> $stable(cfg_regs));

endmodule

bind cfgld_top cfgld_chk #(.NREG(NREG), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .path_fifo(path_fifo), .wr_en(wr_en),
  .rd_en(rd_en), .ser_en(ser_en), .illegal(illegal), .rd_valid(rd_valid),
  .par_we(par_we), .par_re(par_re), .par_idx(par_idx),
  .ser_we(ser_we), .ser_idx(ser_idx), .cfg_regs(cfg_regs)
);

// File: tb/cfgld_top_tb.sv
module cfgld_top_tb;

  localparam int DATA_W = 36;
  localparam int NREG   = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic path_fifo = 1'b1, wr_en = 1'b0, rd_en = 1'b0;
  logic [DATA_W-1:0] wr_data = '0;
  logic ser_clk = 1'b0, ser_en = 1'b0, ser_din = 1'b0;
  logic fifo_wr, fifo_rd, rd_valid, illegal, two_queue;
  logic [7:0] rd_data;
  logic [8*NREG-1:0] cfg_regs;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [7:0] exp_q [NREG];
  int pidx = 0;

  always #2.5 clk = ~clk;

  cfgld_top #(.DATA_W(DATA_W), .NREG(NREG)) u_dut (
    .clk(clk), .rst_n(rst_n), .path_fifo(path_fifo), .wr_en(wr_en),
    .rd_en(rd_en), .wr_data(wr_data), .ser_clk(ser_clk), .ser_en(ser_en),
    .ser_din(ser_din), .fifo_wr(fifo_wr), .fifo_rd(fifo_rd),
    .rd_data(rd_data), .rd_valid(rd_valid), .illegal(illegal),
    .two_queue(two_queue), .cfg_regs(cfg_regs)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
    end
  endtask

  task automatic set_defaults();
    for (int i = 0; i < NREG; i++) exp_q[i] = (i == NREG - 1) ? 8'h80 : 8'h00;
    pidx = 0;
  endtask

  task automatic par_write(input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = {28'hABCDE00, d};
    @(negedge clk);
    wr_en = 1'b0;
    exp_q[pidx] = d;
    pidx = (pidx + 1) % NREG;
  endtask

  task automatic par_read(input string tag);
    @(negedge clk);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    chk(rd_valid === 1'b1 && rd_data === exp_q[pidx], tag, int'(rd_data), int'(exp_q[pidx]));
    pidx = (pidx + 1) % NREG;
  endtask

  task automatic read_all(input string tag);
    for (int i = 0; i < NREG; i++) par_read(tag);
  endtask

  task automatic home_index();
    @(negedge clk);
    path_fifo = 1'b1;
    @(negedge clk);
    path_fifo = 1'b0;
    pidx = 0;
  endtask

  task automatic ser_bit(input logic b);
    @(negedge clk);
    ser_din = b;
    repeat (3) @(negedge clk);
    ser_clk = 1'b1;
    repeat (3) @(negedge clk);
    ser_clk = 1'b0;
  endtask

  task automatic ser_frame(input logic [3:0] a, input logic [7:0] d, input bit expect_write);
    logic [11:0] w;
    w = {a, d};
    @(negedge clk);
    ser_en = 1'b1;
    for (int b = 11; b >= 0; b--) ser_bit(w[b]);
    repeat (8) @(negedge clk);
    ser_en = 1'b0;
    repeat (6) @(negedge clk);
    if (expect_write) exp_q[int'(a) - 1] = d;
  endtask

  task automatic chk_flat(input string tag);
    for (int i = 0; i < NREG; i++)
      chk(cfg_regs[i*8 +: 8] === exp_q[i], tag, int'(cfg_regs[i*8 +: 8]), int'(exp_q[i]));
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    set_defaults();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9, R10: reset state
    chk_flat("R9 reset defaults");
    chk(two_queue === 1'b0, "R10 two_queue after reset", int'(two_queue), 0);
    chk(rd_valid === 1'b0 && illegal === 1'b0, "R9 outputs idle", int'(rd_valid), 0);
    path_fifo = 1'b0;
    read_all("R9 read defaults");

    // R1, R2: fill and read back, then a wrap on both paths
    for (int i = 0; i < NREG; i++) par_write(8'(i * 17 + 3));
    read_all("R1 sequential write/read");
    par_read("R2 read wrap to first");
    par_write(8'h5A);
    par_read("R2 wrap after write");

    // R2: many writes wrap twice, arithmetic model
    home_index();
    for (int i = 0; i < 23; i++) par_write(8'(i * 29 + 101));
    home_index();
    read_all("R2 multi wrap contents");
    chk_flat("R1 flat view");

    // R4: buffer path forwards strobes, registers untouched, index homes
    par_read("R4 advance index");
    @(negedge clk);
    path_fifo = 1'b1;
    wr_en = 1'b1;
    wr_data = 36'h0000000EE;
    #1;
    chk(fifo_wr === 1'b1 && fifo_rd === 1'b0, "R4 fifo_wr forwarded", int'(fifo_wr), 1);
    @(negedge clk);
    wr_en = 1'b0;
    rd_en = 1'b1;
    #1;
    chk(fifo_rd === 1'b1 && fifo_wr === 1'b0, "R4 fifo_rd forwarded", int'(fifo_rd), 1);
    @(negedge clk);
    rd_en = 1'b0;
    chk(rd_valid === 1'b0, "R4 no register read", int'(rd_valid), 0);
    path_fifo = 1'b0;
    pidx = 0;
    read_all("R4 contents and home index");

    // R8: both strobes together
    par_read("R8 advance index");
    @(negedge clk);
    wr_en = 1'b1;
    rd_en = 1'b1;
    wr_data = 36'h0000000C3;
    #1;
    chk(illegal === 1'b1, "R8 illegal raised", int'(illegal), 1);
    @(negedge clk);
    wr_en = 1'b0;
    rd_en = 1'b0;
    chk(rd_valid === 1'b0, "R8 no read pulse", int'(rd_valid), 0);
    par_read("R8 index held");
    home_index();
    read_all("R8 contents unchanged");

    // R7: serial enable while path low
    par_read("R7 advance index");
    @(negedge clk);
    ser_en = 1'b1;
    wr_en = 1'b1;
    wr_data = 36'h0000000AA;
    #1;
    chk(illegal === 1'b1, "R7 illegal raised", int'(illegal), 1);
    @(negedge clk);
    wr_en = 1'b0;
    for (int b = 11; b >= 0; b--) ser_bit(b[0]);
    ser_en = 1'b0;
    repeat (6) @(negedge clk);
    chk(illegal === 1'b0, "R7 illegal cleared", int'(illegal), 0);
    par_read("R7 index held");
    chk_flat("R7 no serial or parallel write");

    // R5, R6: every serial address
    path_fifo = 1'b1;
    for (int a = 0; a < 16; a++)
      ser_frame(4'(a), 8'(a * 11 + 5), (a >= 1 && a <= NREG));
    chk_flat("R5 R6 serial sweep");
    path_fifo = 1'b0;
    pidx = 0;
    read_all("R5 serial contents by read");

    // R5: partial frame discarded
    path_fifo = 1'b1;
    @(negedge clk);
    ser_en = 1'b1;
    for (int b = 0; b < 5; b++) ser_bit(1'b1);
    ser_en = 1'b0;
    repeat (6) @(negedge clk);
    ser_frame(4'd4, 8'h3C, 1'b1);
    chk_flat("R5 partial frame dropped");

    // R10: two_queue follows register 3 bit 0
    ser_frame(4'd3, 8'h01, 1'b1);
    chk(two_queue === 1'b1, "R10 two_queue set", int'(two_queue), 1);
    ser_frame(4'd3, 8'hFE, 1'b1);
    chk(two_queue === 1'b0, "R10 two_queue clear", int'(two_queue), 0);

    // R9: reset again restores defaults
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    set_defaults();
    @(negedge clk);
    chk_flat("R9 defaults after second reset");
    path_fifo = 1'b0;
    read_all("R9 index at first after reset");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule